// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Occupancy Levels

This block carries a stream of data words from a producer clocked by one clock to a consumer clocked by another clock that has no known relation to the first. The producer offers a word by raising put. The word is taken on that write-clock edge unless the queue reports full. The consumer sees the oldest unread word on its data output whenever valid is high. It raises got for one read-clock edge after it has taken that word, and the queue then moves to the next word. A got while valid is low has no effect.

Each side keeps its own binary pointer and publishes a Gray-coded copy. The other side samples that copy through a two-flop synchronizer. Each side also derives a coarse level from the difference between its own pointer and the remote one it has sampled. The write side gives a guaranteed minimum of free slots, and the read side gives a guaranteed minimum of stored words. Both levels lag the true state and can only under-report it, so writes and reads must be gated by full and valid alone. A parameter inserts a register stage on the read data path, and the valid/got contract stays the same.

Top module: `dcf_fifo_fwft`

## Requirements
- R1: Every accepted word is presented exactly once on rd_data, in write order. While rd_valid is high, rd_data already holds the oldest unread word, with no read request needed first.
- R2: The capacity is MIN_DEPTH rounded up to a power of two (16 for the default of 13). With OUT_REG=0, wr_full is high exactly when 16 words are unread in the write side's view of the read pointer.
- R3: A put while wr_full is high is ignored. No word is stored and the write pointer does not move.
- R4: A got while rd_valid is low is ignored. No word is lost and the read pointer does not move.
- R5: While rd_valid is high and got is low, rd_valid stays high and rd_data stays stable on the next read-clock edge.
- R6: With FILL_BITS = N > 0, rd_fill_lvl = min(floor(stored * 2^N / capacity), 2^N - 1). This is a lower bound on the stored words. For N=2 and capacity 16: 8 stored gives 2, and 16 stored gives 3.
- R7: With FREE_BITS = N > 0, wr_free_lvl = min(floor(free * 2^N / capacity), 2^N - 1). This is a lower bound on the free slots. For N=2: an empty queue gives 3, 8 free gives 2, and a full queue gives 0.
- R8: While a side's reset is high, that side returns to its empty state. After reset, rd_valid=0, wr_full=0 and rd_fill_lvl=0.
- R9: With OUT_REG=1, the read data comes from a register stage and R1, R4 and R5 still hold.
- R10: A level parameter set to 0 leaves its port one bit wide and tied to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_put | input | 1 | Offer wr_data for storage |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot; a put is ignored |
| wr_free_lvl | output | max(FREE_BITS,1) | Quantized guaranteed free space |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_valid | output | 1 | rd_data holds the oldest unread word |
| rd_data | output | DATA_W | Head word |
| rd_got | input | 1 | Consumer has taken the head word |
| rd_fill_lvl | output | max(FILL_BITS,1) | Quantized guaranteed stored words |

## Verification
Two copies of the block are driven with the same write stream: one with a combinational head and 2-bit levels, the other with the registered head and both levels disabled. A burst written while the consumer is stalled separates correct head presentation and the level quantization at half and full occupancy from pointer or synchronizer errors. It also fills the queue, so put-while-full can be shown not to add a word. Draining with a got pattern that also pulses while the queue is empty, followed by a gapped stream under steady backpressure, separates correct ordering and pop gating from lost, duplicated or reordered words in both read-path variants.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Address width for a power-of-two depth that covers at least d entries.
    function automatic int unsigned addr_bits(int unsigned d);
        int unsigned n;
        n = 1;
        while ((32'd1 << n) < d) n++;
        return n;
    endfunction

    function automatic logic [31:0] bin2gray(logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Port width for a level output that may be switched off.
    function automatic int unsigned lvl_width(int unsigned bits);
        return (bits == 0) ? 1 : bits;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_level_quant.sv
module dcf_level_quant #(
    parameter int unsigned AW   = 4,
    parameter int unsigned BITS = 2,
    localparam int unsigned OW  = dcf_pkg::lvl_width(BITS)
) (
    input  logic [AW:0]   level,
    output logic [OW-1:0] state
);
    generate
        if (BITS == 0) begin : g_off
            assign state = 1'b0 & (^level);
        end else begin : g_on
            localparam int unsigned SH = AW - BITS;
            logic [AW:0] scaled;
            assign scaled = level >> SH;
            assign state  = (scaled > (AW+1)'((1 << BITS) - 1)) ? '1 : scaled[OW-1:0];
            initial begin
                if (BITS > AW) $error("level bits exceed address bits");
            end
        end
    endgenerate
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
    parameter int unsigned AW        = 4,
    parameter int unsigned FREE_BITS = 2,
    localparam int unsigned OW       = dcf_pkg::lvl_width(FREE_BITS),
    localparam int unsigned DEPTH    = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          put,
    input  logic [AW:0]   rgray_s,
    output logic          full,
    output logic          wr_en,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [OW-1:0] free_lvl
);
    logic [AW:0] wbin, wbin_nx, rbin_s, used, free;

    assign rbin_s  = (AW+1)'(dcf_pkg::gray2bin(32'(rgray_s)));
    assign used    = wbin - rbin_s;
    assign full    = used[AW];
    assign free    = (AW+1)'(DEPTH) - used;
    assign wr_en   = put && !full;
    assign wbin_nx = wbin + (AW+1)'(wr_en);
    assign waddr   = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= (AW+1)'(dcf_pkg::bin2gray(32'(wbin_nx)));
        end
    end

    dcf_level_quant #(.AW(AW), .BITS(FREE_BITS)) free_q_i (
        .level (free),
        .state (free_lvl)
    );

    // R2
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        used <= (AW+1)'(DEPTH));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (put && full) |=> $stable(wbin));
    // R1
    wgray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
    parameter int unsigned AW        = 4,
    parameter int unsigned DW        = 8,
    parameter int unsigned FILL_BITS = 2,
    parameter bit          OUT_REG   = 1'b0,
    localparam int unsigned OW       = dcf_pkg::lvl_width(FILL_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          got,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          valid,
    output logic [DW-1:0] rdata,
    output logic [OW-1:0] fill_lvl
);
    logic [AW:0] rbin, rbin_nx, wbin_s, level;
    logic        ivalid, pop, held;

    assign wbin_s  = (AW+1)'(dcf_pkg::gray2bin(32'(wgray_s)));
    assign ivalid  = (wbin_s != rbin);
    assign rbin_nx = rbin + (AW+1)'(pop);
    assign raddr   = rbin[AW-1:0];
    assign level   = (wbin_s - rbin) + (AW+1)'(held);

    generate
        if (OUT_REG) begin : g_reg
            logic          oreg_v;
            logic [DW-1:0] oreg_d;
            assign pop   = ivalid && (!oreg_v || got);
            assign valid = oreg_v;
            assign rdata = oreg_d;
            assign held  = oreg_v;
            always_ff @(posedge clk) begin
                if (rst) begin
                    oreg_v <= 1'b0;
                    oreg_d <= '0;
                end else if (pop) begin
                    oreg_v <= 1'b1;
                    oreg_d <= mem_q;
                end else if (got) begin
                    oreg_v <= 1'b0;
                end
            end
        end else begin : g_comb
            assign pop   = got && ivalid;
            assign valid = ivalid;
            assign rdata = mem_q;
            assign held  = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= (AW+1)'(dcf_pkg::bin2gray(32'(rbin_nx)));
        end
    end

    dcf_level_quant #(.AW(AW), .BITS(FILL_BITS)) fill_q_i (
        .level (level),
        .state (fill_lvl)
    );

    // R4
    idle_got_chk: assert property (@(posedge clk) disable iff (rst)
        (got && !valid && !ivalid) |=> $stable(rbin));
    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !got) |=> (valid && $stable(rdata)));
    // R1
    rgray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcf_fifo_fwft.sv
module dcf_fifo_fwft #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MIN_DEPTH = 13,
    parameter bit          OUT_REG   = 1'b0,
    parameter int unsigned FREE_BITS = 2,
    parameter int unsigned FILL_BITS = 2,
    localparam int unsigned AW       = dcf_pkg::addr_bits(MIN_DEPTH),
    localparam int unsigned DEPTH    = 1 << AW,
    localparam int unsigned FREE_W   = dcf_pkg::lvl_width(FREE_BITS),
    localparam int unsigned FILL_W   = dcf_pkg::lvl_width(FILL_BITS)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_put,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic [FREE_W-1:0] wr_free_lvl,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_got,
    output logic [FILL_W-1:0] rd_fill_lvl
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0]       wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0]     waddr, raddr;
    logic              wr_en;
    logic [DATA_W-1:0] mem_q;

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[waddr] <= wr_data;
    end
    assign mem_q = mem[raddr];

    dcf_wr_side #(.AW(AW), .FREE_BITS(FREE_BITS)) wr_i (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .put      (wr_put),
        .rgray_s  (rgray_s),
        .full     (wr_full),
        .wr_en    (wr_en),
        .waddr    (waddr),
        .wgray    (wgray),
        .free_lvl (wr_free_lvl)
    );

    dcf_sync #(.W(AW+1)) r2w_i (
        .clk (wr_clk), .rst (wr_rst), .d (rgray), .q (rgray_s)
    );

    dcf_sync #(.W(AW+1)) w2r_i (
        .clk (rd_clk), .rst (rd_rst), .d (wgray), .q (wgray_s)
    );

    dcf_rd_side #(.AW(AW), .DW(DATA_W), .FILL_BITS(FILL_BITS), .OUT_REG(OUT_REG)) rd_i (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .got      (rd_got),
        .wgray_s  (wgray_s),
        .mem_q    (mem_q),
        .raddr    (raddr),
        .rgray    (rgray),
        .valid    (rd_valid),
        .rdata    (rd_data),
        .fill_lvl (rd_fill_lvl)
    );
endmodule

// File: tb/dcf_fifo_fwft_tb.sv
`timescale 1ns/1ps
module dcf_fifo_fwft_tb_top;
    logic       wclk = 1'b0, rclk = 1'b0;
    logic       wrst = 1'b1, rrst = 1'b1;
    logic       put = 1'b0;
    logic [7:0] wdata = '0;
    logic       full0, full1, valid0, valid1, got0 = 1'b0, got1 = 1'b0;
    logic [7:0] data0, data1;
    logic [1:0] free0, fill0;
    logic       free1, fill1;
    logic       rd_run = 1'b0;
    logic [7:0] q0[$], q1[$];
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #4 wclk = ~wclk;
    always #6.5 rclk = ~rclk;

    dcf_fifo_fwft #(.DATA_W(8), .MIN_DEPTH(13), .OUT_REG(1'b0), .FREE_BITS(2), .FILL_BITS(2)) dut_i (
        .wr_clk(wclk), .wr_rst(wrst), .wr_put(put), .wr_data(wdata), .wr_full(full0),
        .wr_free_lvl(free0), .rd_clk(rclk), .rd_rst(rrst), .rd_valid(valid0),
        .rd_data(data0), .rd_got(got0), .rd_fill_lvl(fill0)
    );

    dcf_fifo_fwft #(.DATA_W(8), .MIN_DEPTH(13), .OUT_REG(1'b1), .FREE_BITS(0), .FILL_BITS(0)) dut_reg_i (
        .wr_clk(wclk), .wr_rst(wrst), .wr_put(put), .wr_data(wdata), .wr_full(full1),
        .wr_free_lvl(free1), .rd_clk(rclk), .rd_rst(rrst), .rd_valid(valid1),
        .rd_data(data1), .rd_got(got1), .rd_fill_lvl(fill1)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Driver: waits until both copies have room, then offers one word.
    task automatic put_word(logic [7:0] d);
        @(negedge wclk);
        while (full0 || full1) @(negedge wclk);
        put = 1'b1;
        wdata = d;
        q0.push_back(d);
        q1.push_back(d);
        @(negedge wclk);
        put = 1'b0;
    endtask

    task automatic rwait(int n);
        for (int i = 0; i < n; i++) @(negedge rclk);
    endtask

    // Monitor for the combinational-head copy (R1, R4): got also pulses while empty.
    initial begin
        int cyc = 0;
        forever begin
            @(negedge rclk);
            cyc++;
            if (rd_run) begin
                got0 = (cyc % 3) != 1;
                if (valid0 && got0) begin
                    if (q0.size() == 0) check(1'b0, "R4", data0, -1);
                    else begin
                        check(data0 == q0[0], "R1", data0, q0[0]);
                        void'(q0.pop_front());
                    end
                end
            end else got0 = 1'b0;
        end
    end

    // Monitor for the registered-head copy (R9).
    initial begin
        int cyc = 0;
        forever begin
            @(negedge rclk);
            cyc++;
            if (rd_run) begin
                got1 = (cyc % 4) != 2;
                if (valid1 && got1) begin
                    if (q1.size() == 0) check(1'b0, "R9", data1, -1);
                    else begin
                        check(data1 == q1[0], "R9", data1, q1[0]);
                        void'(q1.pop_front());
                    end
                end
            end else got1 = 1'b0;
        end
    end

    // Watchdog
    initial begin
        for (int i = 0; i < 60000; i++) @(posedge wclk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] head;
        rwait(6);
        @(negedge wclk) wrst = 1'b0;
        @(negedge rclk) rrst = 1'b0;
        rwait(4);
        // R8 reset state
        check(valid0 == 1'b0, "R8", valid0, 0);
        check(full0 == 1'b0, "R8", full0, 0);
        check(fill0 == 2'd0, "R8", fill0, 0);
        check(free0 == 2'd3, "R7", free0, 3);
        check(valid1 == 1'b0, "R8", valid1, 0);

        // Stalled burst of 8 words
        for (int i = 0; i < 8; i++) put_word(8'(8'h10 + i));
        rwait(12);
        check(fill0 == 2'd2, "R6", fill0, 2);
        check(free0 == 2'd2, "R7", free0, 2);
        check(valid0 == 1'b1, "R1", valid0, 1);
        check(data0 == 8'h10, "R1", data0, 8'h10);
        check(data1 == 8'h10, "R9", data1, 8'h10);
        head = data0;
        rwait(5);
        check(valid0 && data0 == head, "R5", data0, head);

        // Fill to capacity
        for (int i = 8; i < 16; i++) put_word(8'(8'h10 + i));
        rwait(12);
        check(full0 == 1'b1, "R2", full0, 1);
        check(free0 == 2'd0, "R7", free0, 0);
        check(fill0 == 2'd3, "R6", fill0, 3);
        check(fill1 == 1'b0 && free1 == 1'b0, "R10", {fill1, free1}, 0);

        // R3: put while full; the registered copy still has one spare slot
        @(negedge wclk);
        put = 1'b1;
        wdata = 8'hEE;
        if (!full1) q1.push_back(8'hEE);
        @(negedge wclk);
        put = 1'b0;
        rwait(4);
        check(full0 == 1'b1, "R3", full0, 1);

        // Drain, then keep pulsing got while empty (R4)
        rd_run = 1'b1;
        while (q0.size() != 0 || q1.size() != 0) @(negedge rclk);
        rwait(10);
        check(valid0 == 1'b0, "R4", valid0, 0);
        check(valid1 == 1'b0, "R9", valid1, 0);
        check(fill0 == 2'd0, "R6", fill0, 0);
        check(free0 == 2'd3, "R7", free0, 3);

        // Gapped stream with readers running
        for (int i = 0; i < 60; i++) begin
            put_word(8'(i * 37 + 5));
            if (i % 4 == 0) @(negedge wclk);
        end
        while (q0.size() != 0 || q1.size() != 0) @(negedge rclk);
        rwait(10);
        check(valid0 == 1'b0, "R1", valid0, 0);
        check(valid1 == 1'b0, "R9", valid1, 0);
        check(fill1 == 1'b0, "R10", fill1, 0);
        finish_run();
    end
endmodule